// File: doc/BRIEF.md
# Accumulator ALU with Packed-BCD Correction

This block is the 8-bit arithmetic and logic stage of a small accumulator-based processor core. Each cycle it receives the accumulator value, a second operand (a data-register value or an immediate), a 4-bit operation code and the current zero, carry and digit-carry flags. It returns the 8-bit result, the next values of the three flags, and a flag telling the sequencer to skip the following instruction.

Register-file addressing, instruction decoding and the multiplier sit outside this block. The block is purely combinational, so its outputs settle in the same cycle as its inputs. The surrounding core picks the destination, either the accumulator or the register, and writes back the returned flags.

Internally, a small decoder turns the operation code into a bundle of strobes: the result source, the adder operand and carry, the logic function and the flag update enables. A datapath uses those strobes to form the result and the flags.

Top module: `alu8_bcd`

## Requirements
- R1: Code 0 (add): result = (acc + opr) mod 256; carry out = carry from bit 7; digit carry out = carry from bit 3 into bit 4; zero out = (result == 0).
- R2: Code 1 (subtract): result = (opr - acc) mod 256; carry out = 1 when opr >= acc (no borrow); digit carry out = 1 when opr[3:0] >= acc[3:0]; zero out = (result == 0).
- R3: Codes 2, 3, 4 and 5 give acc AND opr, acc OR opr, acc XOR opr and NOT opr. Only zero is updated, and carry and digit carry pass through unchanged.
- R4: Code 6 gives opr + 1 and code 7 gives opr - 1, both mod 256. Only zero is updated.
- R5: Code 8 (rotate left through carry) gives {opr[6:0], carryIn} with carry out = opr[7]. Code 9 (rotate right through carry) gives {carryIn, opr[7:1]} with carry out = opr[0]. Zero and digit carry pass through unchanged.
- R6: Code 10 gives {opr[3:0], opr[7:4]}. All three flags pass through unchanged.
- R7: Code 11 (decimal adjust of acc) works in two steps. First, t = acc + 6 when acc[3:0] > 9 or digit carry is set; otherwise t = acc, and t is 9 bits wide. Second, a high correction applies when t carried out of bit 7, or t[7:4] > 9, or carry is set. The result is t[7:0] plus 0x60 when the high correction applies. Carry out = the high correction, zero out = (result == 0), and digit carry passes through unchanged.
- R8: Code 12 gives opr - 1 and code 13 gives opr + 1, both mod 256. For these two codes, skip is high exactly when the result is 0, and all three flags pass through unchanged.
- R9: Skip is low for every code other than 12 and 13.
- R10: Codes 14 and 15 pass opr to the result, and all three flags pass through unchanged.
- R11: The outputs depend only on the present inputs, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accIn | input | 8 | Accumulator operand |
| oprIn | input | 8 | Register or immediate operand |
| opSel | input | 4 | Operation code |
| zIn | input | 1 | Current zero flag |
| cIn | input | 1 | Current carry flag |
| dcIn | input | 1 | Current digit-carry flag |
| result | output | 8 | Operation result |
| zOut | output | 1 | Next zero flag |
| cOut | output | 1 | Next carry flag |
| dcOut | output | 1 | Next digit-carry flag |
| skipNext | output | 1 | Skip the following instruction |

## Verification
The checker samples the block with immediate assertions each time the inputs change. It therefore assumes that every input holds a known 0 or 1, and that all inputs change together rather than glitching through intermediate codes. The bench meets both conditions: it drives all inputs in a single assignment from one process, from time zero onward, and only reads the outputs after a fixed settle delay. The sweep covers every operation code. Add and subtract get every operand pair. The other codes get a strided set of operand pairs with rotating flag inputs, and decimal adjust gets every accumulator value under all eight flag combinations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD     = 4'd0,
    OP_SUB     = 4'd1,
    OP_AND     = 4'd2,
    OP_OR      = 4'd3,
    OP_XOR     = 4'd4,
    OP_COM     = 4'd5,
    OP_INC     = 4'd6,
    OP_DEC     = 4'd7,
    OP_RLC     = 4'd8,
    OP_RRC     = 4'd9,
    OP_SWAP    = 4'd10,
    OP_DAA     = 4'd11,
    OP_DECSKIP = 4'd12,
    OP_INCSKIP = 4'd13,
    OP_PASS0   = 4'd14,
    OP_PASS1   = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {
    SRC_ADDER, SRC_LOGIC, SRC_ROT, SRC_SWAP, SRC_DAA, SRC_PASS
  } resSrc_e;

  typedef enum logic [1:0] {
    Y_ACC, Y_NACC, Y_ONE, Y_ONES
  } addY_e;

  typedef enum logic [1:0] {
    LF_AND, LF_OR, LF_XOR, LF_NOT
  } logicFn_e;

  typedef struct packed {
    resSrc_e  src;
    addY_e    addY;
    logic     addCin;
    logicFn_e logicFn;
    logic     rotLeft;
    logic     updZ;
    logic     updC;
    logic     updDc;
    logic     skipEn;
  } aluCtl_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluCtl_t         ctl
);

  always_comb begin
    ctl         = '0;
    ctl.src     = SRC_PASS;
    ctl.addY    = Y_ACC;
    ctl.logicFn = LF_AND;
    unique case (aluOp_e'(opSel))
      OP_ADD: begin
        ctl.src = SRC_ADDER; ctl.addY = Y_ACC;
        ctl.updZ = 1'b1; ctl.updC = 1'b1; ctl.updDc = 1'b1;
      end
      OP_SUB: begin
        ctl.src = SRC_ADDER; ctl.addY = Y_NACC; ctl.addCin = 1'b1;
        ctl.updZ = 1'b1; ctl.updC = 1'b1; ctl.updDc = 1'b1;
      end
      OP_AND: begin ctl.src = SRC_LOGIC; ctl.logicFn = LF_AND; ctl.updZ = 1'b1; end
      OP_OR:  begin ctl.src = SRC_LOGIC; ctl.logicFn = LF_OR;  ctl.updZ = 1'b1; end
      OP_XOR: begin ctl.src = SRC_LOGIC; ctl.logicFn = LF_XOR; ctl.updZ = 1'b1; end
      OP_COM: begin ctl.src = SRC_LOGIC; ctl.logicFn = LF_NOT; ctl.updZ = 1'b1; end
      OP_INC: begin ctl.src = SRC_ADDER; ctl.addY = Y_ONE;  ctl.updZ = 1'b1; end
      OP_DEC: begin ctl.src = SRC_ADDER; ctl.addY = Y_ONES; ctl.updZ = 1'b1; end
      OP_RLC: begin ctl.src = SRC_ROT; ctl.rotLeft = 1'b1; ctl.updC = 1'b1; end
      OP_RRC: begin ctl.src = SRC_ROT; ctl.rotLeft = 1'b0; ctl.updC = 1'b1; end
      OP_SWAP: ctl.src = SRC_SWAP;
      OP_DAA: begin ctl.src = SRC_DAA; ctl.updZ = 1'b1; ctl.updC = 1'b1; end
      OP_DECSKIP: begin ctl.src = SRC_ADDER; ctl.addY = Y_ONES; ctl.skipEn = 1'b1; end
      OP_INCSKIP: begin ctl.src = SRC_ADDER; ctl.addY = Y_ONE;  ctl.skipEn = 1'b1; end
      default: ctl.src = SRC_PASS;
    endcase
  end

endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluCtl_t           ctl,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] oprIn,
  input  logic              zIn,
  input  logic              cIn,
  input  logic              dcIn,
  output logic [DATA_W-1:0] result,
  output logic              zOut,
  output logic              cOut,
  output logic              dcOut,
  output logic              skipNext
);

  localparam int NIB_W = DATA_W / 2;
  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);
  localparam logic [DATA_W:0]  LOW_FIX   = (DATA_W+1)'(6);
  localparam logic [DATA_W-1:0] HIGH_FIX = DATA_W'(6) << NIB_W;

  // adder shared by add, subtract, increment and decrement
  logic [DATA_W-1:0] addY;
  logic [DATA_W:0]   addSum;
  logic [NIB_W:0]    addLow;

  always_comb begin
    unique case (ctl.addY)
      Y_ACC:   addY = accIn;
      Y_NACC:  addY = ~accIn;
      Y_ONE:   addY = DATA_W'(1);
      default: addY = '1;
    endcase
    addSum = {1'b0, oprIn} + {1'b0, addY} + (DATA_W+1)'(ctl.addCin);
    addLow = {1'b0, oprIn[NIB_W-1:0]} + {1'b0, addY[NIB_W-1:0]} + (NIB_W+1)'(ctl.addCin);
  end

  logic [DATA_W-1:0] logicRes;
  always_comb begin
    unique case (ctl.logicFn)
      LF_AND:  logicRes = accIn & oprIn;
      LF_OR:   logicRes = accIn | oprIn;
      LF_XOR:  logicRes = accIn ^ oprIn;
      default: logicRes = ~oprIn;
    endcase
  end

  logic [DATA_W-1:0] rotRes;
  logic              rotC;
  always_comb begin
    if (ctl.rotLeft) begin
      rotRes = {oprIn[DATA_W-2:0], cIn};
      rotC   = oprIn[DATA_W-1];
    end else begin
      rotRes = {cIn, oprIn[DATA_W-1:1]};
      rotC   = oprIn[0];
    end
  end

  // two-step packed-BCD correction of the accumulator
  logic [DATA_W:0]   daaStep;
  logic              daaHigh;
  logic [DATA_W-1:0] daaRes;
  always_comb begin
    daaStep = {1'b0, accIn};
    if (accIn[NIB_W-1:0] > DIGIT_MAX || dcIn) daaStep = daaStep + LOW_FIX;
    daaHigh = daaStep[DATA_W] || (daaStep[DATA_W-1:NIB_W] > DIGIT_MAX) || cIn;
    daaRes  = daaStep[DATA_W-1:0] + (daaHigh ? HIGH_FIX : '0);
  end

  logic newC, newDc;
  always_comb begin
    newC  = addSum[DATA_W];
    newDc = addLow[NIB_W];
    unique case (ctl.src)
      SRC_ADDER: result = addSum[DATA_W-1:0];
      SRC_LOGIC: result = logicRes;
      SRC_ROT:   begin result = rotRes; newC = rotC; end
      SRC_SWAP:  result = {oprIn[NIB_W-1:0], oprIn[DATA_W-1:NIB_W]};
      SRC_DAA:   begin result = daaRes; newC = daaHigh; end
      default:   result = oprIn;
    endcase
  end

  assign zOut     = ctl.updZ  ? (result == '0) : zIn;
  assign cOut     = ctl.updC  ? newC  : cIn;
  assign dcOut    = ctl.updDc ? newDc : dcIn;
  assign skipNext = ctl.skipEn && (result == '0);

endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] oprIn,
  input  logic [OP_W-1:0]   opSel,
  input  logic              zIn,
  input  logic              cIn,
  input  logic              dcIn,
  output logic [DATA_W-1:0] result,
  output logic              zOut,
  output logic              cOut,
  output logic              dcOut,
  output logic              skipNext
);

  aluCtl_t ctl;

  alu8_ctrl u_ctrl (
    .opSel (opSel),
    .ctl   (ctl)
  );

  alu8_dp #(.DATA_W(DATA_W)) u_dp (
    .ctl      (ctl),
    .accIn    (accIn),
    .oprIn    (oprIn),
    .zIn      (zIn),
    .cIn      (cIn),
    .dcIn     (dcIn),
    .result   (result),
    .zOut     (zOut),
    .cOut     (cOut),
    .dcOut    (dcOut),
    .skipNext (skipNext)
  );

endmodule

// File: rtl/alu8_bcd_chk.sv
module alu8_bcd_chk #(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] accIn,
  input logic [DATA_W-1:0] oprIn,
  input logic [3:0]        opSel,
  input logic              zIn,
  input logic              cIn,
  input logic              dcIn,
  input logic [DATA_W-1:0] result,
  input logic              zOut,
  input logic              cOut,
  input logic              dcOut,
  input logic              skipNext
);

  localparam int NIB_W = DATA_W / 2;

  always_comb begin
    if (opSel == 4'd1) begin
      AST_SUB_NO_BORROW: assert (cOut == (oprIn >= accIn))
        else $error("subtract carry wrong"); // R2
    end
    if (opSel >= 4'd2 && opSel <= 4'd5) begin
      AST_LOGIC_KEEPS_CARRY: assert (cOut == cIn && dcOut == dcIn && zOut == (result == '0))
        else $error("logic flags wrong"); // R3
    end
    if (opSel == 4'd9) begin
      AST_RRC_CARRY_PATH: assert (cOut == oprIn[0] && result[DATA_W-1] == cIn && zOut == zIn)
        else $error("rotate right carry path wrong"); // R5
    end
    if (opSel == 4'd10) begin
      AST_SWAP_FLAGS_HELD: assert (zOut == zIn && cOut == cIn && dcOut == dcIn &&
                                   result == {oprIn[NIB_W-1:0], oprIn[DATA_W-1:NIB_W]})
        else $error("swap wrong"); // R6
    end
    if (opSel == 4'd12 || opSel == 4'd13) begin
      AST_SKIP_ON_ZERO: assert (skipNext == (result == '0) && zOut == zIn && cOut == cIn)
        else $error("counting skip wrong"); // R8
    end else begin
      AST_NO_SPURIOUS_SKIP: assert (!skipNext)
        else $error("skip on non-counting code"); // R9
    end
  end

endmodule

bind alu8_bcd alu8_bcd_chk #(.DATA_W(DATA_W)) u_chk (
  .accIn    (accIn),
  .oprIn    (oprIn),
  .opSel    (opSel),
  .zIn      (zIn),
  .cIn      (cIn),
  .dcIn     (dcIn),
  .result   (result),
  .zOut     (zOut),
  .cOut     (cOut),
  .dcOut    (dcOut),
  .skipNext (skipNext)
);

// File: tb/alu8_bcd_tb.sv
module alu8_bcd_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] accIn = '0, oprIn = '0;
  logic [3:0] opSel = '0;
  logic       zIn = 1'b0, cIn = 1'b0, dcIn = 1'b0;
  logic [7:0] result;
  logic       zOut, cOut, dcOut, skipNext;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  alu8_bcd u_dut (
    .accIn(accIn), .oprIn(oprIn), .opSel(opSel),
    .zIn(zIn), .cIn(cIn), .dcIn(dcIn),
    .result(result), .zOut(zOut), .cOut(cOut), .dcOut(dcOut), .skipNext(skipNext)
  );

  function automatic string reqOf(input int op);
    case (op)
      0: return "R1";  1: return "R2";
      2, 3, 4, 5: return "R3";
      6, 7: return "R4";  8, 9: return "R5";
      10: return "R6";  11: return "R7";
      12, 13: return "R8";
      default: return "R10";
    endcase
  endfunction

  // expected {result, z, c, dc, skip}
  function automatic logic [11:0] model(input int op, input int a, input int b,
                                        input bit z, input bit c, input bit dc);
    int r = b; bit nz = z, nc = c, ndc = dc, sk = 0;
    int t; bit hi;
    case (op)
      0: begin r = (a + b) % 256; nc = (a + b) > 255; ndc = ((a % 16) + (b % 16)) > 15; nz = (r == 0); end
      1: begin r = (b - a + 256) % 256; nc = b >= a; ndc = (b % 16) >= (a % 16); nz = (r == 0); end
      2: begin r = a & b; nz = (r == 0); end
      3: begin r = a | b; nz = (r == 0); end
      4: begin r = a ^ b; nz = (r == 0); end
      5: begin r = 255 - b; nz = (r == 0); end
      6: begin r = (b + 1) % 256; nz = (r == 0); end
      7: begin r = (b + 255) % 256; nz = (r == 0); end
      8: begin r = ((b * 2) % 256) + c; nc = b >= 128; end
      9: begin r = (b / 2) + (c ? 128 : 0); nc = b % 2; end
      10: r = ((b % 16) * 16) + (b / 16);
      11: begin
        t = ((a % 16) > 9 || dc) ? a + 6 : a;
        hi = (t > 255) || (((t % 256) / 16) > 9) || c;
        r = ((t % 256) + (hi ? 96 : 0)) % 256;
        nc = hi; nz = (r == 0);
      end
      12: begin r = (b + 255) % 256; sk = (r == 0); end
      13: begin r = (b + 1) % 256; sk = (r == 0); end
      default: r = b;
    endcase
    return {r[7:0], nz, nc, ndc, sk};
  endfunction

  task automatic apply(input int op, input int a, input int b, input bit z, input bit c,
                       input bit dc, input string req);
    logic [11:0] exp;
    opSel = op[3:0]; accIn = a[7:0]; oprIn = b[7:0]; zIn = z; cIn = c; dcIn = dc;
    #1;
    exp = model(op, a, b, z, c, dc);
    checks++;
    if ({result, zOut, cOut, dcOut, skipNext} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d acc=%02h opr=%02h flags=%b%b%b: got res=%02h z%b c%b dc%b sk%b exp res=%02h z%b c%b dc%b sk%b",
               req, op, a, b, z, c, dc, result, zOut, cOut, dcOut, skipNext,
               exp[11:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  initial begin
    // idle inputs (all zero, code 0) right after start
    #1;
    checks++;
    if (result !== 8'h00 || zOut !== 1'b1 || cOut !== 1'b0 || dcOut !== 1'b0 || skipNext !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: got res=%02h z%b c%b dc%b sk%b exp res=00 z1 c0 dc0 sk0",
               result, zOut, cOut, dcOut, skipNext);
    end
    rstN = 1'b1;

    // directed corners
    apply(0, 8'h15 + 8'h27, 0, 0, 0, 1, "R7 setup");
    apply(11, 8'h3C, 0, 0, 0, 0, "R7");      // 15+27 -> 42
    apply(11, 8'h9A, 0, 0, 0, 0, "R7");      // wraps to 00, carry set
    apply(11, 8'h11, 0, 0, 1, 1, "R7");      // both corrections forced
    apply(1, 8'h05, 8'h05, 0, 0, 0, "R2");   // equal: zero, no borrow
    apply(1, 8'h06, 8'h05, 1, 1, 1, "R2");   // borrow
    apply(0, 8'hFF, 8'h01, 0, 0, 0, "R1");   // full wrap
    apply(12, 0, 8'h01, 0, 1, 0, "R8");      // decrement to zero skips
    apply(13, 0, 8'hFF, 1, 0, 1, "R8");      // increment to zero skips
    apply(12, 0, 8'h00, 0, 0, 0, "R8");      // 00 -> FF no skip
    apply(6, 0, 8'hFF, 0, 1, 1, "R4");       // wrap, C/DC held
    apply(14, 8'h3A, 8'hC5, 1, 0, 1, "R10");
    apply(15, 8'h3A, 8'h00, 0, 1, 0, "R10");

    // main sweep: every code, dense operand pairs for add/subtract (R11: settles in-cycle)
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += ((op <= 1) ? 1 : 3)) begin
          int f = (a + b + op) % 8;
          apply(op, a, b, f[2], f[1], f[0], reqOf(op));
        end
      end
    end

    // decimal adjust under every flag combination
    for (int a = 0; a < 256; a++) begin
      for (int f = 0; f < 8; f++) apply(11, a, a ^ 8'h5A, f[2], f[1], f[0], "R7");
    end

    // R9: no skip on non-counting codes even when result is zero
    for (int op = 0; op < 12; op++) apply(op, 0, 0, 0, 0, 0, "R9");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #900000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired: got running exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule